// File: doc/BRIEF.md
# Sequenced SIMD Montgomery Multiplier

This block multiplies two 256-bit vectors lane by lane. The vectors hold either eight 32-bit elements or sixteen 16-bit elements. In plain mode each lane returns its product cut to the lane width. In modular mode each lane returns a Montgomery product a·b·R⁻¹ mod q, where R is 2^32 for 32-bit lanes and 2^16 for 16-bit lanes. It is intended for number-theoretic-transform butterflies in lattice cryptography. A broadcast option takes one element of the second vector and multiplies every element of the first vector by it.

A single bank of lane multipliers is shared by all the steps of the reduction. A small state machine runs these steps in a fixed order: IDLE, PROD (product), REDM (reduction-factor multiply), ACC (add the multiple of q and shift), CORR (conditional subtraction) and DONE. Each working state lasts three cycles. The transitions are:
- IDLE→PROD on an accepted start.
- PROD→DONE for a plain multiply, or PROD→REDM for a modular one.
- REDM→ACC, then ACC→CORR, then CORR→DONE.
- DONE→IDLE.

The build parameter `OMIT_CSUB` removes the subtraction in CORR. Software then finishes the reduction with a modular add of zero.

Top module: `simd_mont_mul`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` is all zeros and `done_o` is low.
- R2: The element width is set by `half_w_i`. When it is 0, there are eight 32-bit lanes and lane k sits at bits [32k+31:32k]. When it is 1, there are sixteen 16-bit lanes and lane k sits at bits [16k+15:16k].
- R3: With `mont_i`=0, each result lane is the product of the matching operand lanes, cut to the lane width.
- R4: With `bcast_i`=1, every lane of `op_a_i` is multiplied by one lane of `op_b_i`. That lane is selected by `bcast_idx_i`; in 32-bit mode only the low three bits of the index are used. Broadcast works in both plain and modular mode.
- R5: With `mont_i`=1, each lane gives a·b·R⁻¹ mod q.
  - q is taken from `modreg_i[31:0]` and −q⁻¹ mod 2^32 from `modreg_i[63:32]`. In 16-bit mode only the low 16 bits of each field are used.
  - q must be odd and below R/2.
  - When both inputs are below q, the result lies in [0,q).
- R6: `done_o` rises exactly 3 clock edges after the edge that accepts a plain start.
- R7: `done_o` rises exactly 12 clock edges after the edge that accepts a modular start.
- R8: `done_o` is high for exactly one cycle. `result_o` changes only in that cycle and then holds.
- R9: A start is ignored from the accepting edge through the DONE cycle. Such a start has no effect on the result or on the timing of `done_o`.
- R10: With `OMIT_CSUB`=1, each modular lane result lies in [0,2q) and is congruent mod q to the value given in R5. The latency is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| op_a_i | input | 256 | First operand vector |
| op_b_i | input | 256 | Second operand vector |
| half_w_i | input | 1 | 0: 32-bit lanes, 1: 16-bit lanes |
| bcast_i | input | 1 | Broadcast one element of `op_b_i` |
| bcast_idx_i | input | 4 | Lane index used for broadcast |
| mont_i | input | 1 | 0: plain product, 1: Montgomery product |
| modreg_i | input | 64 | q in [31:0], −q⁻¹ mod 2^32 in [63:32] |
| result_o | output | 256 | Result vector, held between operations |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets a set of corner cases, each of which exposes a specific class of fault:
- Lanes holding all-ones operands, and lanes at 0, 1 and q−1. A design that drops the truncation or leaks carries between lanes returns wrong neighbouring lanes. A design with a broken correction step returns values at or above q.
- A broadcast index with its top bit set in 32-bit mode. A design that uses the full index picks the wrong element.
- Start requests injected mid-operation and during the DONE cycle. A design that restarts would overwrite the result or emit a second pulse.
- A second instance built without the correction. It is checked for range [0,2q) and congruence, so a design that still subtracts, or that shifts by the wrong amount, shows up.

// File: rtl/smm_pkg.sv
package smm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROD,
        ST_REDM,
        ST_ACC,
        ST_CORR,
        ST_DONE
    } smm_state_e;

    localparam int LANE_W   = 32;
    localparam int STEP_CYC = 3;
    localparam int CNT_W    = $clog2(STEP_CYC);
endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl
    import smm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mont_i,
    output logic       load_o,
    output logic       step_en_o,
    output logic       fin_o,
    output logic       done_o,
    output smm_state_e state_o
);
    smm_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic mont_q;
    logic last;

    assign last = (cnt_q == CNT_W'(STEP_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PROD;
            ST_PROD: if (last) state_d = mont_q ? ST_REDM : ST_DONE;
            ST_REDM: if (last) state_d = ST_ACC;
            ST_ACC:  if (last) state_d = ST_CORR;
            ST_CORR: if (last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CNT_W'(1);
            if (load_o) mont_q <= mont_i;
        end
    end

    always_comb begin
        load_o    = (state_q == ST_IDLE) && start_i;
        step_en_o = (state_q inside {ST_PROD, ST_REDM, ST_ACC, ST_CORR}) && (cnt_q == '0);
        fin_o     = last && ((state_q == ST_CORR) || ((state_q == ST_PROD) && !mont_q));
        done_o    = (state_q == ST_DONE);
        state_o   = state_q;
    end
endmodule

// File: rtl/smm_lane.sv
module smm_lane
    import smm_pkg::*;
#(
    parameter bit OMIT_CSUB = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_en_i,
    input  smm_state_e        state_i,
    input  logic              half_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic [LANE_W-1:0] q_i,
    input  logic [LANE_W-1:0] qinv_i,
    output logic [LANE_W-1:0] res_o
);
    localparam int PW = 2 * LANE_W;
    localparam int AW = PW + 1;

    logic [LANE_W-1:0] mask, a_q, b_q, m_q, mx, my;
    logic [PW-1:0]     prod;
    logic [AW-1:0]     t_q, sum, shifted, qm;

    assign mask = half_i ? LANE_W'(16'hFFFF) : '1;
    assign qm   = AW'(q_i & mask);

    // One shared multiplier per lane; its operands depend on the step.
    always_comb begin
        unique case (state_i)
            ST_REDM: begin mx = t_q[LANE_W-1:0] & mask; my = qinv_i & mask; end
            ST_ACC:  begin mx = m_q;                    my = q_i & mask;    end
            default: begin mx = a_q;                    my = b_q;           end
        endcase
    end

    assign prod    = {{LANE_W{1'b0}}, mx} * {{LANE_W{1'b0}}, my};
    assign sum     = t_q + AW'(prod);
    assign shifted = half_i ? (sum >> 16) : (sum >> LANE_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            m_q <= '0;
            t_q <= '0;
        end else begin
            if (load_i) begin
                a_q <= a_i;
                b_q <= b_i;
            end
            if (step_en_i) begin
                unique case (state_i)
                    ST_PROD: t_q <= AW'(prod);
                    ST_REDM: m_q <= prod[LANE_W-1:0] & mask;
                    ST_ACC:  t_q <= shifted;
                    ST_CORR: if (!OMIT_CSUB && (t_q >= qm)) t_q <= t_q - qm;
                    default: ;
                endcase
            end
        end
    end

    assign res_o = t_q[LANE_W-1:0] & mask;
endmodule

// File: rtl/simd_mont_mul.sv
module simd_mont_mul
    import smm_pkg::*;
#(
    parameter int VEC_W     = 256,
    parameter bit OMIT_CSUB = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [VEC_W-1:0]             op_a_i,
    input  logic [VEC_W-1:0]             op_b_i,
    input  logic                         half_w_i,
    input  logic                         bcast_i,
    input  logic [$clog2(VEC_W/16)-1:0]  bcast_idx_i,
    input  logic                         mont_i,
    input  logic [2*LANE_W-1:0]          modreg_i,
    output logic [VEC_W-1:0]             result_o,
    output logic                         done_o
);
    localparam int SLOTS  = VEC_W / 16;
    localparam int WSLOTS = VEC_W / LANE_W;
    localparam int IDX_W  = $clog2(SLOTS);

    logic       load, step_en, fin;
    smm_state_e state;
    logic       half_q;
    logic [LANE_W-1:0] q_q, qinv_q, bsel16, bsel32;
    logic [LANE_W-1:0] slot_a [SLOTS];
    logic [LANE_W-1:0] slot_b [SLOTS];
    logic [LANE_W-1:0] slot_r [SLOTS];
    logic [VEC_W-1:0]  pack16, pack32;

    assign bsel16 = LANE_W'(op_b_i[{bcast_idx_i, 4'b0} +: 16]);
    assign bsel32 = op_b_i[{bcast_idx_i[IDX_W-2:0], 5'b0} +: LANE_W];

    smm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mont_i    (mont_i),
        .load_o    (load),
        .step_en_o (step_en),
        .fin_o     (fin),
        .done_o    (done_o),
        .state_o   (state)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [LANE_W-1:0] a_wide, b_wide;
        if (i < WSLOTS) begin : g_wide
            assign a_wide = op_a_i[LANE_W*i +: LANE_W];
            assign b_wide = op_b_i[LANE_W*i +: LANE_W];
            assign pack32[LANE_W*i +: LANE_W] = slot_r[i];
        end else begin : g_half_only
            assign a_wide = '0;
            assign b_wide = '0;
        end
        assign slot_a[i] = half_w_i ? LANE_W'(op_a_i[16*i +: 16]) : a_wide;
        assign slot_b[i] = bcast_i  ? (half_w_i ? bsel16 : bsel32)
                                    : (half_w_i ? LANE_W'(op_b_i[16*i +: 16]) : b_wide);
        assign pack16[16*i +: 16] = slot_r[i][15:0];

        smm_lane #(.OMIT_CSUB(OMIT_CSUB)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .step_en_i (step_en),
            .state_i   (state),
            .half_i    (half_q),
            .a_i       (slot_a[i]),
            .b_i       (slot_b[i]),
            .q_i       (q_q),
            .qinv_i    (qinv_q),
            .res_o     (slot_r[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q   <= 1'b0;
            q_q      <= '0;
            qinv_q   <= '0;
            result_o <= '0;
        end else begin
            if (load) begin
                half_q <= half_w_i;
                q_q    <= modreg_i[LANE_W-1:0];
                qinv_q <= modreg_i[2*LANE_W-1:LANE_W];
            end
            if (fin) result_o <= half_q ? pack16 : pack32;
        end
    end
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mont_i,
    input logic             done_o,
    input logic [VEC_W-1:0] result_o
);
    logic       trk, mont_t;
    logic [3:0] cyc;

    // Independent tracker: edges since the start that opened the operation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk    <= 1'b0;
            mont_t <= 1'b0;
            cyc    <= '0;
        end else if (!trk) begin
            if (start_i) begin
                trk    <= 1'b1;
                mont_t <= mont_i;
                cyc    <= '0;
            end
        end else if (done_o) begin
            trk <= 1'b0;
        end else begin
            cyc <= cyc + 4'd1;
        end
    end

    a_r6_plain_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mont_t) |-> (cyc == 4'd3));
    a_r7_mont_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mont_t) |-> (cyc == 4'd12));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);
    a_r9_done_owned: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> trk);
endmodule

bind simd_mont_mul smm_checker #(.VEC_W(VEC_W)) u_smm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mont_i   (mont_i),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/simd_mont_mul_bench.sv
module simd_mont_mul_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] op_a = '0, op_b = '0;
    logic         half = 1'b0, bc = 1'b0, mont = 1'b0;
    logic [3:0]   idx = '0;
    logic [63:0]  modreg = '0;
    logic [255:0] res, res_nc;
    logic         done, done_nc;
    int n_chk = 0, n_fail = 0;

    localparam logic [31:0] Q32 = 32'd8380417;
    localparam logic [31:0] Q16 = 32'd3329;

    always #5 clk = ~clk;

    simd_mont_mul u_simd_mont_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
        .half_w_i(half), .bcast_i(bc), .bcast_idx_i(idx), .mont_i(mont),
        .modreg_i(modreg), .result_o(res), .done_o(done));

    simd_mont_mul #(.OMIT_CSUB(1'b1)) u_simd_mont_mul_nc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
        .half_w_i(half), .bcast_i(bc), .bcast_idx_i(idx), .mont_i(mont),
        .modreg_i(modreg), .result_o(res_nc), .done_o(done_nc));

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] neg_inv(input logic [31:0] q);
        logic [31:0] inv = q;
        for (int i = 0; i < 5; i++) inv = inv * (32'd2 - q * inv);
        return -inv;
    endfunction

    function automatic logic [31:0] mref(input logic [31:0] x, input logic [31:0] y,
                                        input logic [31:0] q, input int w);
        longint unsigned t = ((longint'(x) * longint'(y)) % longint'(q));
        for (int i = 0; i < w; i++) begin
            if (t[0]) t = t + longint'(q);
            t = t >> 1;
        end
        return t[31:0];
    endfunction

    function automatic logic [255:0] expect_v(input bit m, input bit h, input bit b_c,
            input logic [3:0] ix, input logic [255:0] a, input logic [255:0] b,
            input logic [31:0] q);
        logic [255:0] r = '0;
        for (int i = 0; i < (h ? 16 : 8); i++) begin
            logic [31:0] ai, bi, p;
            if (h) begin
                ai = {16'b0, a[16*i +: 16]};
                bi = b_c ? {16'b0, b[16*ix +: 16]} : {16'b0, b[16*i +: 16]};
                p  = m ? mref(ai, bi, q, 16) : ((ai * bi) & 32'hFFFF);
                r[16*i +: 16] = p[15:0];
            end else begin
                ai = a[32*i +: 32];
                bi = b_c ? b[32*ix[2:0] +: 32] : b[32*i +: 32];
                p  = m ? mref(ai, bi, q, 32) : (ai * bi);
                r[32*i +: 32] = p;
            end
        end
        return r;
    endfunction

    function automatic bit nc_ok(input logic [255:0] got, input logic [255:0] ex,
                                 input bit h, input logic [31:0] q);
        for (int i = 0; i < (h ? 16 : 8); i++) begin
            longint unsigned g = h ? longint'(got[16*i +: 16]) : longint'(got[32*i +: 32]);
            longint unsigned e = h ? longint'(ex[16*i +: 16])  : longint'(ex[32*i +: 32]);
            if (g >= 2 * longint'(q) || (g % longint'(q)) != e) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [255:0] rnd_vec(input int seed, input bit h, input logic [31:0] lim);
        logic [31:0]  s = seed;
        logic [255:0] v = '0;
        for (int i = 0; i < (h ? 16 : 8); i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            if (h) v[16*i +: 16] = (lim == 0) ? s[31:16] : 16'(s % lim);
            else   v[32*i +: 32] = (lim == 0) ? s : (s % lim);
        end
        return v;
    endfunction

    // Runs one operation and checks its latency, pulse width and quiet aftermath.
    task automatic run_op(input string tag, input bit m, input bit h, input bit b_c,
            input logic [3:0] ix, input logic [255:0] a, input logic [255:0] b,
            input int poke, output logic [255:0] r, output logic [255:0] r_nc);
        int lat = m ? 12 : 3;
        bit lat_ok = 1'b1, quiet_ok = 1'b1;
        @(negedge clk);
        mont = m; half = h; bc = b_c; idx = ix; op_a = a; op_b = b;
        modreg = h ? {neg_inv(Q16), Q16} : {neg_inv(Q32), Q32};
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (done !== (k == lat) || done_nc !== (k == lat)) lat_ok = 1'b0;
            if (k == poke) begin start = 1'b1; op_a = ~a; end
            else start = 1'b0;
        end
        r = res; r_nc = res_nc;
        n_chk++;
        if (!lat_ok) begin
            n_fail++;
            $display("FAIL %s R6/R7 latency: actual done timing wrong, expected pulse after %0d edges", tag, lat);
        end
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (done !== 1'b0 || res !== r) quiet_ok = 1'b0;
        end
        n_chk++;
        if (!quiet_ok) begin
            n_fail++;
            $display("FAIL %s R8/R9 after done: actual done=%b res=%h, expected done=0 res=%h", tag, done, res, r);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset result", res, '0);
        chk("R1 reset done", {255'b0, done}, '0);
    endtask

    task automatic t_plain32();
        logic [255:0] a = rnd_vec(11, 0, 0), b = rnd_vec(12, 0, 0), r, rn;
        a[31:0] = 32'hFFFF_FFFF; b[31:0] = 32'hFFFF_FFFF;
        run_op("plain32", 0, 0, 0, 0, a, b, 0, r, rn);
        chk("R3 R2 plain 32-bit lanes", r, expect_v(0, 0, 0, 0, a, b, 0));
    endtask

    task automatic t_plain16();
        logic [255:0] a = rnd_vec(21, 1, 0), b = rnd_vec(22, 1, 0), r, rn;
        a[255:240] = 16'hFFFF; b[255:240] = 16'hFFFF;
        run_op("plain16", 0, 1, 0, 0, a, b, 0, r, rn);
        chk("R3 R2 plain 16-bit lanes", r, expect_v(0, 1, 0, 0, a, b, 0));
    endtask

    task automatic t_bcast();
        logic [255:0] a = rnd_vec(31, 0, 0), b = rnd_vec(32, 0, 0), r, rn;
        run_op("bcast32", 0, 0, 1, 4'd13, a, b, 0, r, rn);
        chk("R4 broadcast 32-bit, index top bit ignored", r, expect_v(0, 0, 1, 4'd5, a, b, 0));
        a = rnd_vec(33, 1, Q16); b = rnd_vec(34, 1, Q16);
        run_op("bcast16m", 1, 1, 1, 4'd13, a, b, 0, r, rn);
        chk("R4 R5 broadcast 16-bit Montgomery", r, expect_v(1, 1, 1, 4'd13, a, b, Q16));
    endtask

    task automatic t_mont32();
        logic [255:0] a = rnd_vec(41, 0, Q32), b = rnd_vec(42, 0, Q32), r, rn, e;
        run_op("mont32", 1, 0, 0, 0, a, b, 0, r, rn);
        e = expect_v(1, 0, 0, 0, a, b, Q32);
        chk("R5 Montgomery 32-bit lanes", r, e);
        chk("R10 no-subtract variant 32-bit", {255'b0, nc_ok(rn, e, 0, Q32)}, 256'd1);
    endtask

    task automatic t_mont16();
        logic [255:0] a = rnd_vec(51, 1, Q16), b = rnd_vec(52, 1, Q16), r, rn, e;
        run_op("mont16", 1, 1, 0, 0, a, b, 0, r, rn);
        e = expect_v(1, 1, 0, 0, a, b, Q16);
        chk("R5 Montgomery 16-bit lanes", r, e);
        chk("R10 no-subtract variant 16-bit", {255'b0, nc_ok(rn, e, 1, Q16)}, 256'd1);
    endtask

    task automatic t_mont_edge();
        logic [255:0] a, b, r, rn, e;
        a = {32'd12345, Q32 >> 1, Q32 - 32'd2, 32'd2, Q32 - 32'd1, Q32 - 32'd1, 32'd1, 32'd0};
        b = {Q32 - 32'd1, Q32 - 32'd1, Q32 - 32'd2, 32'd1, 32'd1, Q32 - 32'd1, Q32 - 32'd1, Q32 - 32'd1};
        run_op("mont_edge", 1, 0, 0, 0, a, b, 0, r, rn);
        e = expect_v(1, 0, 0, 0, a, b, Q32);
        chk("R5 Montgomery boundary operands", r, e);
        chk("R10 no-subtract boundary operands", {255'b0, nc_ok(rn, e, 0, Q32)}, 256'd1);
    endtask

    task automatic t_busy();
        logic [255:0] a = rnd_vec(61, 0, Q32), b = rnd_vec(62, 0, Q32), r, rn;
        run_op("busy_mid", 1, 0, 0, 0, a, b, 5, r, rn);
        chk("R9 start mid-operation ignored", r, expect_v(1, 0, 0, 0, a, b, Q32));
        a = rnd_vec(63, 0, 0); b = rnd_vec(64, 0, 0);
        run_op("busy_done", 0, 0, 0, 0, a, b, 3, r, rn);
        chk("R9 start in done cycle ignored", r, expect_v(0, 0, 0, 0, a, b, 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog: actual run hung, expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain32();
        t_plain16();
        t_bcast();
        t_mont32();
        t_mont16();
        t_mont_edge();
        t_busy();
        report();
    end
endmodule